// File: doc/BRIEF.md
# Dual-Channel Line CRC Checker

This block sits on a word-aligned 20-bit high-definition video stream that carries two interleaved 10-bit channels: luma in bits 19:10 and chroma in bits 9:0. It keeps one line CRC for each channel. Each CRC covers the words from the start of active picture through the line-number words that follow the end-of-active-video marker. The block checks each computed CRC against the two CRC words that the stream carries after those line-number words. A mismatch in a channel raises that channel's error flag.

Upstream logic finds the timing reference sequences and reports where they sit with two one-cycle strobes. One strobe marks the identifier word of the start-of-active-video sequence and the other marks the identifier word of the end-of-active-video sequence. When insertion is enabled, the block writes its own CRC words over the embedded ones in both channels. Data leaves the block one clock after it enters.

Top module: `lcrc_check`

## Requirements
- R1: While reset (`rst_n` low) is held, `dout` is zero and both error flags are low.
- R2: Every word that is not replaced appears on `dout` unchanged, exactly one clock after it is presented on `din`.
- R3: Each channel's CRC starts from all zeros at the word after the word flagged by `sav_id`. It then absorbs every word up to and including the second word after the word flagged by `eav_id`, which is the second line-number word, and holds its value until the next `sav_id`.
- R4: The CRC uses the generator x^18+x^5+x^4+1. Each 10-bit word is fed least significant bit first into a right-shifting register r. For each bit, fb = bit XOR r[0], r is shifted right by one, and when fb is 1, r is XORed with 18'h23000. The first CRC word is {~r[8], r[8:0]} and the second is {~r[17], r[17:9]}.
- R5: The luma flag `crc_err_y` is driven only by bits 19:10 and the chroma flag `crc_err_c` is driven only by bits 9:0. A corruption in one channel never raises the other channel's flag.
- R6: The third word after the `eav_id` word is the first embedded CRC word and the fourth is the second. A flag goes high if either embedded CRC word differs from the computed value, and goes low if both match. The flag changes only on the clock edge that puts the second CRC word on `dout`, and holds between those edges.
- R7: With `crc_ins_en` high, the two embedded CRC word positions on `dout` carry the computed CRC words of R4 in both channels.
- R8: With `crc_ins_en` low, the embedded CRC words pass to `dout` untouched.
- R9: The error flags always judge the embedded words as received, so a corrupted line still raises its flag while insertion repairs the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 20 | Aligned input word, luma 19:10, chroma 9:0 |
| eav_id | input | 1 | High on the end-of-active-video identifier word |
| sav_id | input | 1 | High on the start-of-active-video identifier word |
| crc_ins_en | input | 1 | Replace embedded CRC words with computed ones |
| dout | output | 20 | Output word, one clock behind `din` |
| crc_err_y | output | 1 | Luma CRC mismatch flag |
| crc_err_c | output | 1 | Chroma CRC mismatch flag |

## Verification
Lines with random lengths and random active-picture data are sent with correct CRC words. These lines show that the CRC span and the bit order agree with an independent serial model, both on the flags and on the inserted words. Directed lines then corrupt one CRC word at a time in one channel at a time. These lines separate the two flags and separate a check on the first CRC word from a check on the second. Corrupted lines sent with insertion on separate comparison of the received words from comparison of the repaired words. Random lines with insertion toggled confirm that data is left untouched when insertion is off.

// File: rtl/lcrc_pkg.sv
package lcrc_pkg;
    localparam int WORD_W  = 10;
    localparam int CRC_W   = 18;
    localparam int HALF_W  = CRC_W / 2;
    localparam int NUM_CH  = 2;
    localparam int BUS_W   = WORD_W * NUM_CH;
    localparam int POS_W   = 3;
    localparam logic [CRC_W-1:0] CRC_MASK = 18'h23000;

    // Word offsets counted from the end-of-active identifier word
    localparam logic [POS_W-1:0] OFS_LN1  = 3'd2;
    localparam logic [POS_W-1:0] OFS_CRC0 = 3'd3;
    localparam logic [POS_W-1:0] OFS_CRC1 = 3'd4;

    typedef struct packed {
        logic [POS_W-1:0] ofs;
        logic             span;
    } pos_state_t;

    typedef struct packed {
        logic [CRC_W-1:0]  crc;
        logic              mis;
        logic              err;
        logic [WORD_W-1:0] word;
    } lane_state_t;

    // Fold one word into the register, least significant bit first
    function automatic logic [CRC_W-1:0] crc_next(input logic [CRC_W-1:0] c,
                                                  input logic [WORD_W-1:0] w);
        logic [CRC_W-1:0] r;
        logic             fb;
        r = c;
        for (int i = 0; i < WORD_W; i++) begin
            fb = r[0] ^ w[i];
            r  = r >> 1;
            if (fb) r = r ^ CRC_MASK;
        end
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] crc_fmt(input logic [HALF_W-1:0] part);
        return {~part[HALF_W-1], part};
    endfunction
endpackage

// File: rtl/lcrc_pos.sv
module lcrc_pos
    import lcrc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic eav_id,
    input  logic sav_id,
    output logic span,
    output logic at_crc0,
    output logic at_crc1
);
    pos_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (eav_id)
            st_d.ofs = 3'd1;
        else if (st_q.ofs != '0 && st_q.ofs < OFS_CRC1)
            st_d.ofs = st_q.ofs + 3'd1;
        else
            st_d.ofs = '0;

        if (sav_id)
            st_d.span = 1'b1;
        else if (st_q.ofs == OFS_LN1)
            st_d.span = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign span    = st_q.span;
    assign at_crc0 = (st_q.ofs == OFS_CRC0);
    assign at_crc1 = (st_q.ofs == OFS_CRC1);

    assert_span_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sav_id |=> span);
    assert_crc_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (at_crc0 && !eav_id) |=> at_crc1);
    assert_span_close_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (at_crc0 && !sav_id) |=> !span);
endmodule

// File: rtl/lcrc_lane.sv
module lcrc_lane
    import lcrc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_in,
    input  logic              clr,
    input  logic              span,
    input  logic              at_crc0,
    input  logic              at_crc1,
    input  logic              ins_en,
    output logic [WORD_W-1:0] word_out,
    output logic              err
);
    lane_state_t st_d, st_q;
    logic [WORD_W-1:0] exp0, exp1;

    assign exp0 = crc_fmt(st_q.crc[HALF_W-1:0]);
    assign exp1 = crc_fmt(st_q.crc[CRC_W-1:HALF_W]);

    always_comb begin
        st_d = st_q;
        if (clr)       st_d.crc = '0;
        else if (span) st_d.crc = crc_next(st_q.crc, word_in);

        if (at_crc0) st_d.mis = (word_in != exp0);
        if (at_crc1) st_d.err = st_q.mis | (word_in != exp1);

        if (ins_en && at_crc0)      st_d.word = exp0;
        else if (ins_en && at_crc1) st_d.word = exp1;
        else                        st_d.word = word_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_out = st_q.word;
    assign err      = st_q.err;

    assert_err_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !at_crc1 |=> $stable(err));
    assert_ins_fmt_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_en && (at_crc0 || at_crc1)) |=> (word_out[WORD_W-1] != word_out[WORD_W-2]));
    assert_passthru_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ins_en |=> (word_out == $past(word_in)));
    assert_crc_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !span) |=> $stable(st_q.crc));
endmodule

// File: rtl/lcrc_check.sv
module lcrc_check
    import lcrc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] din,
    input  logic             eav_id,
    input  logic             sav_id,
    input  logic             crc_ins_en,
    output logic [BUS_W-1:0] dout,
    output logic             crc_err_y,
    output logic             crc_err_c
);
    logic              span, at_crc0, at_crc1;
    logic [NUM_CH-1:0] err_vec;

    lcrc_pos u_pos (
        .clk     (clk),
        .rst_n   (rst_n),
        .eav_id  (eav_id),
        .sav_id  (sav_id),
        .span    (span),
        .at_crc0 (at_crc0),
        .at_crc1 (at_crc1)
    );

    // Lane 0 is chroma (low word), lane 1 is luma (high word)
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
        lcrc_lane u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .word_in  (din[ch*WORD_W +: WORD_W]),
            .clr      (sav_id),
            .span     (span),
            .at_crc0  (at_crc0),
            .at_crc1  (at_crc1),
            .ins_en   (crc_ins_en),
            .word_out (dout[ch*WORD_W +: WORD_W]),
            .err      (err_vec[ch])
        );
    end

    assign crc_err_y = err_vec[1];
    assign crc_err_c = err_vec[0];

    assert_flags_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !at_crc1 |=> ($stable(crc_err_y) && $stable(crc_err_c)));
endmodule

// File: tb/tb_lcrc_check.sv
module tb_lcrc_check;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] din = '0;
    logic        eav_id = 1'b0, sav_id = 1'b0, crc_ins_en = 1'b0;
    logic [19:0] dout;
    logic        crc_err_y, crc_err_c;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    logic [17:0] m_cy = '0, m_cc = '0;
    logic        m_span = 1'b0;
    logic        m_mis_y = 1'b0, m_mis_c = 1'b0;
    logic        x_ey = 1'b0, x_ec = 1'b0;

    lcrc_check dut (.clk(clk), .rst_n(rst_n), .din(din), .eav_id(eav_id),
                    .sav_id(sav_id), .crc_ins_en(crc_ins_en), .dout(dout),
                    .crc_err_y(crc_err_y), .crc_err_c(crc_err_c));

    always #2.5 clk = ~clk;

    function automatic logic [17:0] ref_crc(input logic [17:0] c, input logic [9:0] w);
        logic [17:0] r = c;
        for (int b = 0; b < 10; b++) begin
            logic fb = w[b] ^ r[0];
            r = {fb, r[17:1]} ^ ({18{fb}} & 18'h03000);
        end
        return r;
    endfunction

    function automatic logic [9:0] fmt(input logic [8:0] p);
        return {~p[8], p};
    endfunction

    task automatic check(input string tag, input logic [19:0] act, input logic [19:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // kind: 0 plain, 2 second line-number word, 3 first CRC word, 4 second CRC word
    task automatic put(input logic [19:0] w, input logic e, input logic s, input int kind);
        logic [19:0] xo;
        din = w; eav_id = e; sav_id = s;
        xo = w;
        if (kind == 3) begin
            m_mis_y = (w[19:10] != fmt(m_cy[8:0]));
            m_mis_c = (w[9:0]   != fmt(m_cc[8:0]));
            if (crc_ins_en) xo = {fmt(m_cy[8:0]), fmt(m_cc[8:0])};
        end else if (kind == 4) begin
            x_ey = m_mis_y | (w[19:10] != fmt(m_cy[17:9]));
            x_ec = m_mis_c | (w[9:0]   != fmt(m_cc[17:9]));
            if (crc_ins_en) xo = {fmt(m_cy[17:9]), fmt(m_cc[17:9])};
        end
        if (s) begin
            m_cy = '0; m_cc = '0; m_span = 1'b1;
        end else if (m_span) begin
            m_cy = ref_crc(m_cy, w[19:10]);
            m_cc = ref_crc(m_cc, w[9:0]);
            if (kind == 2) m_span = 1'b0;
        end
        @(negedge clk);
        if (kind >= 3)
            check(crc_ins_en ? "R3 R4 R7 crc word" : "R8 crc word", dout, xo);
        else
            check("R2 passthrough", dout, xo);
        check((kind == 4 && crc_ins_en) ? "R9 R5 R6 luma flag" : "R5 R6 luma flag",
              {19'd0, crc_err_y}, {19'd0, x_ey});
        check((kind == 4 && crc_ins_en) ? "R9 R5 R6 chroma flag" : "R5 R6 chroma flag",
              {19'd0, crc_err_c}, {19'd0, x_ec});
    endtask

    function automatic logic [19:0] rnd20();
        return 20'($urandom);
    endfunction

    // bad: bit0 luma crc0, bit1 luma crc1, bit2 chroma crc0, bit3 chroma crc1
    task automatic line(input int act, input bit ins, input logic [3:0] bad);
        logic [19:0] c0, c1;
        logic [9:0]  fl;
        crc_ins_en = ins;
        put(20'hFFFFF, 0, 0, 0); put(20'h00000, 0, 0, 0); put(20'h00000, 0, 0, 0);
        put({10'h2AC, 10'h2AC}, 0, 1, 0);
        for (int i = 0; i < act; i++) put(rnd20(), 0, 0, 0);
        put(20'hFFFFF, 0, 0, 0); put(20'h00000, 0, 0, 0); put(20'h00000, 0, 0, 0);
        put({10'h274, 10'h274}, 1, 0, 0);
        put(rnd20(), 0, 0, 0);
        put(rnd20(), 0, 0, 2);
        fl = 10'($urandom_range(1, 1023));
        c0 = {fmt(m_cy[8:0]), fmt(m_cc[8:0])};
        c1 = {fmt(m_cy[17:9]), fmt(m_cc[17:9])};
        if (bad[0]) c0[19:10] ^= fl;
        if (bad[1]) c1[19:10] ^= fl;
        if (bad[2]) c0[9:0]   ^= fl;
        if (bad[3]) c1[9:0]   ^= fl;
        put(c0, 0, 0, 3);
        put(c1, 0, 0, 4);
        for (int i = 0; i < int'($urandom_range(2, 6)); i++) put(rnd20(), 0, 0, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2718));
        din = 20'hABCDE;
        repeat (3) @(negedge clk);
        check("R1 reset dout", dout, 20'h0);
        check("R1 reset flags", {18'd0, crc_err_y, crc_err_c}, 20'h0);
        rst_n = 1'b1;
        put(20'h12345, 0, 0, 0);
        // directed corners
        line(1, 0, 4'b0000);
        line(5, 1, 4'b0000);
        line(8, 0, 4'b0001);
        line(8, 0, 4'b0000);
        line(8, 0, 4'b0010);
        line(8, 0, 4'b0100);
        line(8, 0, 4'b1000);
        line(8, 1, 4'b1111);
        line(3, 1, 4'b0010);
        line(3, 1, 4'b0000);
        // random lines
        for (int n = 0; n < 40; n++)
            line(int'($urandom_range(1, 40)), bit'($urandom_range(0, 1)),
                 ($urandom_range(0, 2) == 0) ? 4'($urandom) : 4'b0000);
        finish_run();
    end
endmodule